// File: doc/BRIEF.md
# Two-Rank Converter Code Latch

This block builds a 12-bit converter code from a narrower bus and keeps it in a second register rank. Software or a bus master writes the code in two pieces: an 8-bit low part and a 4-bit high part. Each piece goes into its own first-rank register. A separate load command then copies the joined pair into the converter register as one 12-bit word. Because the output only changes on that load, the converter never sees a half-written code.

Every control input is active low. A master write strobe gates all three load paths. If the strobe and every enable are asserted together, data flows through both ranks in a single edge, so the final piece and the transfer cost one cycle. A separate mid-scale clear input forces the converter register to the offset-binary centre code. It acts immediately and takes priority over every write. It does not disturb the first rank. A parameter chooses the output format: offset binary, or two's complement, which is offset binary with its top bit flipped. A change flag marks every change of the converter register.

Top module: `dac_dbuf_if`

## Requirements
- R1: After rst_ni is released, code_o is 800h in offset format, upd_o is 0, and both first-rank registers hold 0.
- R2: While wr_ni is high at a rising edge, no register changes, whatever lo_en_ni, hi_en_ni, ld_ni and data_i are.
- R3: At a rising edge with wr_ni and lo_en_ni both low, the low register takes data_i[7:0].
- R4: At a rising edge with wr_ni and hi_en_ni both low, the high register takes data_i[11:8].
- R5: At a rising edge with wr_ni and ld_ni both low, the converter register takes {high, low}. A part whose enable is also low at that edge contributes the new data_i bits instead of the held value. code_o shows the result after that edge.
- R6: When wr_ni, lo_en_ni, hi_en_ni and ld_ni are all low at one edge, code_o equals data_i from that edge.
- R7: While mid_ni is low, the converter register is 800h, and it takes that value without waiting for a clock edge. Writes to the converter register are ignored in that time.
- R8: mid_ni does not affect the first rank. Loads into the first rank continue while mid_ni is low. A load after mid_ni is released transfers the last held pair.
- R9: upd_o goes high when the converter register value changes and stays high until the next rising edge. A load that leaves the value unchanged gives no pulse.
- R10: With FMT set to FMT_TWOS, code_o is the converter register with bit 11 inverted, so the mid-scale clear shows as 000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| data_i | input | 12 | Code bus; bits 7:0 low part, bits 11:8 high part |
| wr_ni | input | 1 | Master write strobe, active low |
| lo_en_ni | input | 1 | Low-part load enable, active low |
| hi_en_ni | input | 1 | High-part load enable, active low |
| ld_ni | input | 1 | Converter-register load, active low |
| mid_ni | input | 1 | Asynchronous clear to mid-scale, active low |
| code_o | output | 12 | Converter code in the selected format |
| upd_o | output | 1 | High from a converter-register change until the next edge |

## Verification
The stability and change-flag properties assume that mid_ni is held steady around each sampling edge. They also assume that a pulse on mid_ni never falls and rises again within one clock period, since such a pulse would change the converter register with no trace at either edge. The stimulus changes mid_ni only at falling edges and holds each level for at least a full cycle. The immediate effect of the clear is checked one nanosecond after it is asserted, before any rising edge.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;
endpackage

// File: rtl/dbuf_in_rank.sv
module dbuf_in_rank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= d_i;
  end

  // flow-through value for a transfer in the same edge
  assign nxt_o = en_i ? d_i : q;
  assign q_o   = q;
endmodule

// File: rtl/dbuf_conv_rank.sv
module dbuf_conv_rank #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mid_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         upd_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q, last_q;
  logic         clr_n;

  assign clr_n = rst_ni & mid_ni;

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n)    q <= MID;
    else if (ld_i) q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= MID;
    else         last_q <= q;
  end

  assign upd_o = (q != last_q);
  assign q_o   = q;

  a_r7_mid_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mid_ni |-> q == MID);

  a_r9_upd_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q != $past(q)) |-> upd_o);
endmodule

// File: rtl/dbuf_out_fmt.sv
module dbuf_out_fmt
  import dac_dbuf_pkg::*;
#(
  parameter int   W   = 12,
  parameter fmt_e FMT = FMT_OFFSET
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (FMT == FMT_TWOS) begin : g_twos
    assign q_o = {~d_i[W-1], d_i[W-2:0]};
  end else begin : g_offset
    assign q_o = d_i;
  end
endmodule

// File: rtl/dac_dbuf_if.sv
module dac_dbuf_if
  import dac_dbuf_pkg::*;
#(
  parameter int   LO_W = 8,
  parameter int   HI_W = 4,
  parameter fmt_e FMT  = FMT_OFFSET,
  localparam int  W    = LO_W + HI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         wr_ni,
  input  logic         lo_en_ni,
  input  logic         hi_en_ni,
  input  logic         ld_ni,
  input  logic         mid_ni,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic              lo_we, hi_we, cv_we;
  logic [LO_W-1:0]   lo_q, lo_nxt;
  logic [HI_W-1:0]   hi_q, hi_nxt;
  logic [W-1:0]      conv_q;

  // master strobe gates every load path
  assign lo_we = ~wr_ni & ~lo_en_ni;
  assign hi_we = ~wr_ni & ~hi_en_ni;
  assign cv_we = ~wr_ni & ~ld_ni;

  dbuf_in_rank #(.W(LO_W)) u_lo (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(lo_we),
    .d_i   (data_i[LO_W-1:0]), .q_o(lo_q), .nxt_o(lo_nxt)
  );

  dbuf_in_rank #(.W(HI_W)) u_hi (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(hi_we),
    .d_i   (data_i[W-1:LO_W]), .q_o(hi_q), .nxt_o(hi_nxt)
  );

  dbuf_conv_rank #(.W(W)) u_cv (
    .clk_i (clk_i), .rst_ni(rst_ni), .mid_ni(mid_ni), .ld_i(cv_we),
    .d_i   ({hi_nxt, lo_nxt}), .q_o(conv_q), .upd_o(upd_o)
  );

  dbuf_out_fmt #(.W(W), .FMT(FMT)) u_fmt (
    .d_i(conv_q), .q_o(code_o)
  );

  a_r2_hold_without_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(lo_q) && $stable(hi_q) && (!mid_ni || $stable(conv_q)));

  a_r3_low_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !lo_en_ni) |=> lo_q == $past(data_i[LO_W-1:0]));

  a_r4_high_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !hi_en_ni) |=> hi_q == $past(data_i[W-1:LO_W]));

  a_r6_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !lo_en_ni && !hi_en_ni && !ld_ni && mid_ni)
      |=> (!mid_ni || conv_q == $past(data_i)));
endmodule

// File: tb/sim_dac_dbuf_if.sv
module sim_dac_dbuf_if;
  import dac_dbuf_pkg::*;

  typedef struct {
    logic [11:0] code;
    logic [11:0] code2;
    logic        upd;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] data_i = '0;
  logic        wr_ni = 1'b1, lo_en_ni = 1'b1, hi_en_ni = 1'b1, ld_ni = 1'b1;
  logic        mid_ni = 1'b1;
  logic [11:0] code_o, code2_o;
  logic        upd_o, upd2_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];

  logic [7:0]  m_lo = '0;
  logic [3:0]  m_hi = '0;
  logic [11:0] m_cv = 12'h800;
  logic        m_mid = 1'b1;

  always #4 clk_i = ~clk_i;

  dac_dbuf_if u0 (
    .clk_i, .rst_ni, .data_i, .wr_ni, .lo_en_ni, .hi_en_ni, .ld_ni, .mid_ni,
    .code_o(code_o), .upd_o(upd_o)
  );

  dac_dbuf_if #(.FMT(FMT_TWOS)) u1 (
    .clk_i, .rst_ni, .data_i, .wr_ni, .lo_en_ni, .hi_en_ni, .ld_ni, .mid_ni,
    .code_o(code2_o), .upd_o(upd2_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [12:0] act,
                     input logic [12:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of controls, push the result due after the edge
  task automatic step(input logic [11:0] d, input logic wr, input logic lo,
                      input logic hi, input logic ld, input logic mid,
                      input string tag);
    logic [7:0]  nlo;
    logic [3:0]  nhi;
    logic [11:0] old, ncv;
    exp_t e;
    @(negedge clk_i);
    data_i = d; wr_ni = wr; lo_en_ni = lo; hi_en_ni = hi; ld_ni = ld; mid_ni = mid;
    old = m_cv;
    nlo = (!wr && !lo) ? d[7:0]  : m_lo;
    nhi = (!wr && !hi) ? d[11:8] : m_hi;
    if (!mid)          ncv = 12'h800;
    else if (!wr && !ld) ncv = {nhi, nlo};
    else               ncv = old;
    if (!mid && m_mid) begin
      #1;
      chk(code_o == 12'h800, {"R7 immediate clear ", tag}, {1'b0, code_o}, 13'h0800);
      chk(upd_o == (old != 12'h800), {"R9 clear flag ", tag}, {12'h0, upd_o},
          {12'h0, old != 12'h800});
    end
    m_lo = nlo; m_hi = nhi; m_cv = ncv; m_mid = mid;
    e.code  = ncv;
    e.code2 = ncv ^ 12'h800;
    e.upd   = mid ? (ncv != old) : 1'b0;
    e.tag   = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(code_o == e.code && upd_o == e.upd && code2_o == e.code2, e.tag,
          {code_o, upd_o}, {e.code, e.upd});
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(code_o == 12'h800 && upd_o == 1'b0, "R1 reset state", {code_o, upd_o}, 13'h1000);
    chk(code2_o == 12'h000, "R10 reset twos", {1'b0, code2_o}, 13'h0);
    step(12'h000, 0, 1, 1, 0, 1, "R1 empty first rank loads 000");
    step(12'h35A, 0, 0, 1, 1, 1, "R3 low only, output held");
    step(12'h3A5, 0, 1, 0, 1, 1, "R4 high only, output held");
    step(12'hFFF, 1, 1, 1, 0, 1, "R2 load blocked by strobe");
    step(12'h000, 0, 1, 1, 0, 1, "R5 transfer 3A5+5A");
    step(12'h111, 0, 1, 1, 0, 1, "R9 same value no pulse");
    step(12'hFFF, 1, 0, 0, 0, 1, "R2 all enables, strobe high");
    step(12'hEEE, 0, 1, 1, 1, 1, "R2 strobe alone");
    step(12'hABC, 0, 0, 0, 0, 1, "R6 all transparent ABC");
    step(12'h0F0, 0, 0, 1, 0, 1, "R5 low flows through");
    step(12'h500, 0, 1, 0, 0, 1, "R5 high flows through");
    step(12'h011, 0, 0, 1, 0, 0, "R7 clear beats load, R8 low loads");
    step(12'hFFF, 0, 0, 0, 0, 0, "R7 clear holds mid-scale");
    step(12'h022, 0, 1, 1, 1, 1, "R8 release keeps 800");
    step(12'h000, 0, 1, 1, 0, 1, "R8 transfer retained FF");
    step(12'h7FF, 0, 0, 0, 0, 1, "R6 boundary 7FF");
    step(12'h800, 0, 0, 0, 0, 1, "R10 boundary 800");
    step(12'hFFF, 0, 0, 0, 0, 1, "R6 boundary FFF");
    step(12'h000, 0, 0, 0, 0, 1, "R6 boundary 000");
    step(12'h000, 1, 1, 1, 1, 1, "R9 idle no pulse");
    @(posedge clk_i);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule